// File: doc/BRIEF.md
# Supply-Loss Guard for a Byte-Wide Static RAM

This block stands between a host and a small byte-wide static RAM and keeps the stored bytes safe while the supply comes and goes. Three digitized supply-monitor flags are its view of the supply. The first says the supply is above the deselect trip point. The second says it is above the upper window limit. The third says it is above the lower battery switchover threshold. The block re-times each flag and filters out short spikes. From the cleaned flags it decides whether host strobes may reach the array, whether read data may drive the bus, and whether the array runs from the external supply or from the battery.

A falling trip flag cuts off all access. A falling switchover flag moves the source select to battery. When the supply returns, the source select goes back to external first, and access stays blocked. Access opens again only after the supply has stayed above the upper limit for a fixed recovery count. Even then, chip enable must be seen inactive once before any access is let through. The host strobes are active low and act in single cycles: a write is taken at the clock edge, and a read drives data combinationally while it is allowed.

Top module: `pfd_guard`

## Requirements
- R1: While access is open, `ce_n`=0 with `we_n`=0 stores `wdata` at `addr` on the clock edge. `ce_n`=0, `we_n`=1 and `oe_n`=0 drive the stored byte on `rdata` with `rdata_oe`=1. Otherwise `rdata_oe`=0 and `rdata`=0.
- R2: From the cycle after the filtered trip flag goes low, `gated_ce_n`, `gated_we_n` and `gated_oe_n` are all 1 and `rdata_oe` is 0. Address, data and strobe inputs then change nothing.
- R3: One cycle after the filtered switchover flag is low, `pwr_sel_batt` is 1. The array contents do not change while it stays 1.
- R4: One cycle after the filtered switchover flag returns high in battery mode, `pwr_sel_batt` is 0 and access is still blocked.
- R5: Access opens only after the filtered upper-limit flag has been high for `REC_CYC` consecutive cycles with the trip and switchover flags high.
- R6: If the upper-limit or trip flag drops during the recovery count, the block goes back to protection, and the count starts again from zero on the next rise.
- R7: After recovery, no access passes until `ce_n` has been sampled at 1. A chip enable held low through power-up does not write.
- R8: A trip during a write sequence can change only the location being written. Every other location keeps its value.
- R9: During reset and just after it, the block is protected, all gated strobes are 1, `rdata_oe` is 0 and `pwr_sel_batt` is 0.
- R10: Each supply flag passes a two-stage synchronizer and then a filter that accepts a new level only after `FILT_CYC` consecutive cycles. A shorter pulse has no effect on access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_trip_ok | input | 1 | Supply above deselect trip point |
| sup_win_hi | input | 1 | Supply above upper window limit |
| sup_sw_ok | input | 1 | Supply above battery switchover threshold |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| addr | input | AW | Byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, zero when not driven |
| rdata_oe | output | 1 | Drive enable for the tri-state data bus |
| gated_ce_n | output | 1 | Chip enable passed to the array |
| gated_we_n | output | 1 | Write enable passed to the array |
| gated_oe_n | output | 1 | Output enable passed to the array |
| pwr_sel_batt | output | 1 | 1 selects battery, 0 selects external supply |

## Verification
The checks assume that the supply thresholds are ordered. When the upper-limit flag is high the trip flag is also high, and when the trip flag is high the switchover flag is also high. A cleaned flag can therefore never show a supply that is above a higher threshold but below a lower one. The stimulus raises the flags from the lowest threshold upward and drops them from the highest downward. Each flag is changed at the inactive clock edge, so the synchronizer captures a level that is already stable. Glitches are the one exception to the ordering. The only glitch applied is a short dip of the trip flag, held for fewer cycles than the filter length.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_PROT   = 2'd1,
    ST_BATT   = 2'd2,
    ST_REC    = 2'd3
  } pfd_state_t;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_OK   = 0;
  localparam int unsigned FLAG_HI   = 1;
  localparam int unsigned FLAG_SW   = 2;
endpackage

// File: rtl/pfd_flag_filter.sv
module pfd_flag_filter #(
  parameter int unsigned FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          sync1, sync2;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      clean <= 1'b0;
      run   <= '0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
      if (sync2 != clean) begin
        if (run == LAST) begin
          clean <= sync2;
          run   <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int unsigned REC_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flt_ok,
  input  logic       flt_hi,
  input  logic       flt_sw,
  input  logic       ce_n,
  output pfd_state_t state,
  output logic       access_ok
);
  localparam int unsigned CW = $clog2(REC_CYC + 1);
  localparam logic [CW-1:0] DONE = CW'(REC_CYC - 1);

  pfd_state_t    nxt;
  logic [CW-1:0] rec_cnt;
  logic          armed;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_NORMAL: begin
        if (!flt_sw)      nxt = ST_BATT;
        else if (!flt_ok) nxt = ST_PROT;
      end
      ST_PROT: begin
        if (!flt_sw)                nxt = ST_BATT;
        else if (flt_hi && flt_ok)  nxt = ST_REC;
      end
      ST_BATT: begin
        if (flt_sw) nxt = ST_PROT;
      end
      ST_REC: begin
        if (!flt_sw)                 nxt = ST_BATT;
        else if (!flt_hi || !flt_ok) nxt = ST_PROT;
        else if (rec_cnt == DONE)    nxt = ST_NORMAL;
      end
      default: nxt = ST_PROT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_PROT;
      rec_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      state   <= nxt;
      rec_cnt <= (state == ST_REC) ? rec_cnt + 1'b1 : '0;
      if (state != ST_NORMAL) armed <= 1'b0;
      else if (ce_n)          armed <= 1'b1;
    end
  end

  assign access_ok = (state == ST_NORMAL) && armed && flt_ok;
endmodule

// File: rtl/pfd_store.sv
module pfd_store #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_word
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
  end

  assign rd_word = cells[addr];
endmodule

// File: rtl/pfd_guard.sv
module pfd_guard
  import pfd_pkg::*;
#(
  parameter int unsigned AW       = 6,
  parameter int unsigned DW       = 8,
  parameter int unsigned REC_CYC  = 20,
  parameter int unsigned FILT_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_trip_ok,
  input  logic          sup_win_hi,
  input  logic          sup_sw_ok,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          gated_ce_n,
  output logic          gated_we_n,
  output logic          gated_oe_n,
  output logic          pwr_sel_batt
);
  logic [NUM_FLAGS-1:0] raw_flags;
  logic [NUM_FLAGS-1:0] flt_flags;
  pfd_state_t           state;
  logic                 access_ok;
  logic                 wr_sel, rd_sel;
  logic [DW-1:0]        rd_word;

  assign raw_flags[FLAG_OK] = sup_trip_ok;
  assign raw_flags[FLAG_HI] = sup_win_hi;
  assign raw_flags[FLAG_SW] = sup_sw_ok;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    pfd_flag_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_flags[g]),
      .clean (flt_flags[g])
    );
  end

  pfd_ctrl #(.REC_CYC(REC_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .flt_ok    (flt_flags[FLAG_OK]),
    .flt_hi    (flt_flags[FLAG_HI]),
    .flt_sw    (flt_flags[FLAG_SW]),
    .ce_n      (ce_n),
    .state     (state),
    .access_ok (access_ok)
  );

  assign wr_sel = access_ok && !ce_n && !we_n;
  assign rd_sel = access_ok && !ce_n && we_n && !oe_n;

  pfd_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .wr_en   (wr_sel),
    .addr    (addr),
    .wdata   (wdata),
    .rd_word (rd_word)
  );

  assign gated_ce_n   = !(access_ok && !ce_n);
  assign gated_we_n   = !wr_sel;
  assign gated_oe_n   = !rd_sel;
  assign rdata_oe     = rd_sel;
  assign rdata        = rd_sel ? rd_word : '0;
  assign pwr_sel_batt = (state == ST_BATT);
endmodule

// File: rtl/pfd_guard_chk.sv
module pfd_guard_chk
  import pfd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input pfd_state_t state,
  input logic       flt_ok,
  input logic       flt_sw,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       rdata_oe,
  input logic       gated_ce_n,
  input logic       gated_we_n,
  input logic       pwr_sel_batt
);
  assert_read_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!oe_n && !ce_n && we_n));

  assert_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_NORMAL || !flt_ok) |-> (gated_we_n && gated_ce_n && !rdata_oe));

  assert_to_battery_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_sw |=> pwr_sel_batt);

  assert_back_external_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BATT && flt_sw) |=> (!pwr_sel_batt && gated_we_n));

  assert_entry_via_recovery_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && $past(state) != ST_NORMAL) |-> $past(state) == ST_REC);

  assert_first_cycle_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && $past(state) != ST_NORMAL) |-> (gated_we_n && gated_ce_n));
endmodule

bind pfd_guard pfd_guard_chk u_pfd_guard_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state        (state),
  .flt_ok       (flt_flags[pfd_pkg::FLAG_OK]),
  .flt_sw       (flt_flags[pfd_pkg::FLAG_SW]),
  .ce_n         (ce_n),
  .we_n         (we_n),
  .oe_n         (oe_n),
  .rdata_oe     (rdata_oe),
  .gated_ce_n   (gated_ce_n),
  .gated_we_n   (gated_we_n),
  .pwr_sel_batt (pwr_sel_batt)
);

// File: tb/pfd_guard_bench.sv
module pfd_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int REC = 20;
  localparam int FILT = 3;
  localparam int LAT = FILT + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_trip_ok = 1'b0, sup_win_hi = 1'b0, sup_sw_ok = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe, gated_ce_n, gated_we_n, gated_oe_n, pwr_sel_batt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_guard #(.AW(AW), .DW(DW), .REC_CYC(REC), .FILT_CYC(FILT)) u_pfd_guard (
    .clk(clk), .rst_n(rst_n), .sup_trip_ok(sup_trip_ok), .sup_win_hi(sup_win_hi),
    .sup_sw_ok(sup_sw_ok), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .gated_ce_n(gated_ce_n),
    .gated_we_n(gated_we_n), .gated_oe_n(gated_oe_n), .pwr_sel_batt(pwr_sel_batt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: 0 open, 1 guarded, 2 battery, 3 counting
  int m_s1[3], m_s2[3], m_f[3], m_c[3];
  int m_st = 1, m_cnt = 0;
  bit m_arm = 0;
  bit [DW-1:0] m_mem [int];

  function automatic int raw_in(input int i);
    case (i)
      0: return int'(sup_trip_ok);
      1: return int'(sup_win_hi);
      default: return int'(sup_sw_ok);
    endcase
  endfunction

  function automatic bit m_open();
    return (m_st == 0) && m_arm && (m_f[0] == 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_c[i] = 0; end
      m_st = 1; m_cnt = 0; m_arm = 0;
    end else begin
      int nst;
      if (m_open() && !ce_n && !we_n) m_mem[int'(addr)] = wdata;
      nst = m_st;
      case (m_st)
        0: if (m_f[2] == 0) nst = 2; else if (m_f[0] == 0) nst = 1;
        1: if (m_f[2] == 0) nst = 2; else if (m_f[1] == 1 && m_f[0] == 1) nst = 3;
        2: if (m_f[2] == 1) nst = 1;
        default: if (m_f[2] == 0) nst = 2;
                 else if (m_f[1] == 0 || m_f[0] == 0) nst = 1;
                 else if (m_cnt == REC - 1) nst = 0;
      endcase
      if (m_st != 0) m_arm = 0; else if (ce_n) m_arm = 1;
      m_cnt = (m_st == 3) ? m_cnt + 1 : 0;
      m_st = nst;
      for (int i = 0; i < 3; i++) begin
        if (m_s2[i] != m_f[i]) begin
          if (m_c[i] == FILT - 1) begin m_f[i] = m_s2[i]; m_c[i] = 0; end
          else m_c[i] = m_c[i] + 1;
        end else m_c[i] = 0;
        m_s2[i] = m_s1[i];
        m_s1[i] = raw_in(i);
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit op, rd, wr;
      op = m_open();
      rd = op && !ce_n && we_n && !oe_n;
      wr = op && !ce_n && !we_n;
      check(gated_ce_n == !(op && !ce_n), "R2 gated_ce_n", gated_ce_n, !(op && !ce_n));
      check(gated_we_n == !wr, "R5 gated_we_n", gated_we_n, !wr);
      check(gated_oe_n == !rd, "R7 gated_oe_n", gated_oe_n, !rd);
      check(rdata_oe == rd, "R1 rdata_oe", rdata_oe, rd);
      check(pwr_sel_batt == (m_st == 2), "R3 pwr_sel_batt", pwr_sel_batt, m_st == 2);
      if (!rd) check(rdata == '0, "R1 rdata idle", rdata, 0);
      else if (m_mem.exists(int'(addr)))
        check(rdata == m_mem[int'(addr)], "R8 rdata", rdata, m_mem[int'(addr)]);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    addr = AW'(a); wdata = DW'(d); ce_n = 0; we_n = 1'b0;
    tick(1);
    ce_n = 1; we_n = 1;
    tick(1);
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    addr = AW'(a); ce_n = 0; we_n = 1; oe_n = 0;
    #1;
    check(rdata_oe == 1'b1 && rdata == DW'(exp), req, rdata, exp);
    tick(1);
    ce_n = 1; oe_n = 1;
    tick(1);
  endtask

  task automatic power_up();
    sup_sw_ok = 1; tick(2);
    sup_trip_ok = 1; tick(2);
    sup_win_hi = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R9: reset state
    check(gated_ce_n && gated_we_n && gated_oe_n && !rdata_oe, "R9 strobes in reset",
          {gated_ce_n, gated_we_n, gated_oe_n, rdata_oe}, 4'b1110);
    check(pwr_sel_batt == 0, "R9 source in reset", pwr_sel_batt, 0);
    rst_n = 1;
    check(pwr_sel_batt == 0 && gated_we_n, "R9 after release", pwr_sel_batt, 0);
    tick(LAT + 2);

    // R7: enable held active with a write through power-up
    ce_n = 0; we_n = 0; addr = 6'd5; wdata = 8'hEE;
    power_up();
    tick(LAT + REC + 6);
    check(gated_we_n == 1, "R7 held enable blocked", gated_we_n, 1);
    ce_n = 1; we_n = 1;
    tick(1);

    // R1: writes and reads with distinct patterns
    for (int i = 0; i < 8; i++) wr(i, (i * 37 + 11) & 8'hFF);
    for (int i = 0; i < 8; i++) rd_chk(i, (i * 37 + 11) & 8'hFF, "R1 read back");
    addr = 6'd2; ce_n = 0; oe_n = 1; #1;
    check(rdata_oe == 0 && rdata == 0, "R1 oe_n high no drive", rdata_oe, 0);
    tick(1); ce_n = 1;
    tick(1);

    // R10: trip dip shorter than filter
    sup_trip_ok = 0; tick(FILT - 1); sup_trip_ok = 1;
    tick(LAT + 2);
    wr(9, 8'h5A);
    rd_chk(9, 8'h5A, "R10 glitch ignored");

    // R8 + R2: trip during a write sequence at address 3
    addr = 6'd3; ce_n = 0; we_n = 0; wdata = 8'hC3;
    sup_win_hi = 0; sup_trip_ok = 0;
    for (int k = 0; k < LAT + 4; k++) begin wdata = wdata + 1'b1; tick(1); end
    addr = 6'd4; wdata = 8'h00; #1;
    check(gated_we_n == 1, "R2 write blocked", gated_we_n, 1);
    we_n = 1; oe_n = 0; #1;
    check(rdata_oe == 0 && gated_oe_n == 1, "R2 read blocked", rdata_oe, 0);
    ce_n = 1; oe_n = 1;
    tick(2);

    // R3: drop below switchover
    sup_sw_ok = 0;
    tick(LAT + 2);
    check(pwr_sel_batt == 1, "R3 battery select", pwr_sel_batt, 1);
    addr = 6'd1; wdata = 8'h00; ce_n = 0; we_n = 0;
    tick(4);
    ce_n = 1; we_n = 1;

    // R4: back above switchover, still guarded
    sup_sw_ok = 1;
    tick(LAT + 2);
    ce_n = 0; we_n = 0; addr = 6'd1; #1;
    check(pwr_sel_batt == 0, "R4 external select", pwr_sel_batt, 0);
    check(gated_we_n == 1, "R4 still protected", gated_we_n, 1);
    ce_n = 1; we_n = 1;
    tick(1);

    // R6: dip of upper flag during recovery restarts the count
    sup_trip_ok = 1; tick(2);
    sup_win_hi = 1;
    tick(LAT + REC / 2);
    sup_win_hi = 0; tick(FILT + 3); sup_win_hi = 1;
    tick(REC / 2 - 4);
    addr = 6'd0; ce_n = 0; oe_n = 0; #1;
    check(rdata_oe == 0, "R6 count restarted", rdata_oe, 0);
    ce_n = 1; oe_n = 1;
    tick(LAT + REC + 4);

    // R5 + R8: access back, neighbours intact
    rd_chk(0, 11, "R5 access reopened");
    rd_chk(1, (37 + 11) & 8'hFF, "R8 neighbour 1 kept");
    rd_chk(2, (74 + 11) & 8'hFF, "R8 neighbour 2 kept");
    rd_chk(4, (148 + 11) & 8'hFF, "R8 neighbour 4 kept");
    rd_chk(7, (259 + 11) & 8'hFF, "R8 neighbour 7 kept");

    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule